// File: doc/BRIEF.md
# Border-Flood Binary Hole Filler

This block closes enclosed holes in a small binary image held on chip. A bit-wide image store is loaded pixel by pixel through a write port. A second bit-wide store, the working mask, starts with its outermost ring of pixels at background and every pixel inside that ring at foreground. Each rising edge on the frame-sync input starts one raster pass. During the pass the mask shrinks: background is flooded inward from the border wherever the loaded image is itself background.

During a pass the raster generator visits one pixel per clock, from left to right and then top to bottom. A mask pixel is cleared when three things hold: it is still set, the loaded image is background at that spot, and at least one of its four direct neighbours in the mask is already clear. A neighbour that falls outside the image counts as clear. Updates take effect at once, so later pixels in the same pass see earlier ones. Every visited mask value is streamed out as an 8-bit pixel (0 or 255) together with its raster index.

Passes repeat, one per frame, until a pass changes nothing. The done flag then rises, and the streamed mask is the filled image.

States: `ST_IDLE` waits for a frame edge. `ST_SCAN` visits the pixels. `ST_WRAP` takes one cycle after the last pixel to judge convergence.

Transitions:
- `ST_IDLE`→`ST_SCAN` on a frame edge.
- `ST_SCAN`→`ST_WRAP` after the last pixel.
- `ST_SCAN`→`ST_SCAN` on a frame edge, which restarts the pass.
- `ST_WRAP`→`ST_IDLE`, or `ST_WRAP`→`ST_SCAN` on a frame edge.

Top module: `hole_fill`

## Requirements
- R1: After reset `done` is 0 and `pix_valid` is 0.
- R2: A write with `ld_en` high in `ST_IDLE` stores background at `ld_addr` when `ld_pix` is 0 and foreground for any nonzero value. The same write clears `done` and returns the mask to its initial form: border pixels 0, inner pixels 1.
- R3: A rising edge on `frame_sync` starts a pass. The pass streams exactly IMG_W*IMG_H pixels on consecutive cycles, with `pix_idx` = row*IMG_W + column running from 0 upward.
- R4: Holding `frame_sync` high starts only one pass. Only a low-to-high change starts a pass.
- R5: A mask pixel is cleared only when it is set, the loaded image is background there, and a 4-neighbour in the mask is clear. Foreground pixels inside the border always stream as 255.
- R6: `pix_out` is 8'd255 for a set mask pixel and 8'd0 for a clear one. The value shown is the one after that pixel's update.
- R7: Updates are written in place. A background run reaching rightward or downward from the border is cleared entirely within one pass.
- R8: `done` rises at the end of the first pass that changes no mask pixel. It stays high through later passes until the next accepted load.
- R9: Border pixels always stream as 0.
- R10: A frame edge during a pass abandons it. Streaming resumes from index 0 with the change record cleared.
- R11: Writes requested while a pass is running are ignored. They neither alter the image nor clear `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | active-low asynchronous reset |
| frame_sync | input | 1 | frame strobe; a rising edge starts a pass |
| ld_en | input | 1 | image write enable |
| ld_addr | input | $clog2(IMG_W*IMG_H) | raster index to write |
| ld_pix | input | 8 | pixel to write, 0 = background |
| pix_valid | output | 1 | streamed pixel is valid |
| pix_idx | output | $clog2(IMG_W*IMG_H) | raster index of streamed pixel |
| pix_out | output | 8 | mask pixel, 0 or 255 |
| done | output | 1 | mask has converged |

## Verification
The hardest case to reach from the ports is slow convergence. This happens when background must creep against the raster order, so one pixel clears per pass and `done` must stay low until the true fixed point. A vertical background channel opening onto the bottom border produces this case, and so does an image where a pass is restarted mid-way. The bench counts passes against values worked out by hand. Random images are each run to convergence and compared with a bench-side fixed point. That fixed point is computed by whole-frame relaxation rather than in-place raster order.

// File: rtl/hf_pkg.sv
package hf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_WRAP = 2'd2
    } hf_state_e;
endpackage

// File: rtl/hf_raster.sv
module hf_raster #(
    parameter int W = 8,
    parameter int H = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         step,
    output logic [$clog2(W)-1:0]         x,
    output logic [$clog2(H)-1:0]         y,
    output logic [$clog2(W*H)-1:0]       idx,
    output logic                         last
);
    localparam int XW = $clog2(W);
    localparam int YW = $clog2(H);
    localparam int NW = $clog2(W*H);

    assign last = (x == XW'(W-1)) && (y == YW'(H-1));
    assign idx  = NW'(y) * NW'(W) + NW'(x);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x <= '0;
            y <= '0;
        end else if (clr) begin
            x <= '0;
            y <= '0;
        end else if (step) begin
            if (x == XW'(W-1)) begin
                x <= '0;
                y <= last ? '0 : y + 1'b1;
            end else begin
                x <= x + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hf_decide.sv
module hf_decide #(
    parameter int W = 8,
    parameter int H = 8
) (
    input  logic [W*H-1:0]               aux_v,
    input  logic                         bin_bit,
    input  logic [$clog2(W)-1:0]         x,
    input  logic [$clog2(H)-1:0]         y,
    input  logic [$clog2(W*H)-1:0]       idx,
    output logic                         new_bit,
    output logic                         clr
);
    localparam int XW = $clog2(W);
    localparam int YW = $clog2(H);
    localparam int NW = $clog2(W*H);

    logic n_up, n_dn, n_lf, n_rt, cand;

    always_comb begin
        n_up = (y != '0)          ? aux_v[idx - NW'(W)] : 1'b0;
        n_dn = (y != YW'(H-1))    ? aux_v[idx + NW'(W)] : 1'b0;
        n_lf = (x != '0)          ? aux_v[idx - NW'(1)] : 1'b0;
        n_rt = (x != XW'(W-1))    ? aux_v[idx + NW'(1)] : 1'b0;
        cand = aux_v[idx] && !bin_bit;
        clr  = cand && !(n_up && n_dn && n_lf && n_rt);
        new_bit = aux_v[idx] && !clr;
    end
endmodule

// File: rtl/hole_fill.sv
module hole_fill #(
    parameter int IMG_W = 8,
    parameter int IMG_H = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               frame_sync,
    input  logic                               ld_en,
    input  logic [$clog2(IMG_W*IMG_H)-1:0]     ld_addr,
    input  logic [7:0]                         ld_pix,
    output logic                               pix_valid,
    output logic [$clog2(IMG_W*IMG_H)-1:0]     pix_idx,
    output logic [7:0]                         pix_out,
    output logic                               done
);
    import hf_pkg::*;

    localparam int N  = IMG_W * IMG_H;
    localparam int XW = $clog2(IMG_W);
    localparam int YW = $clog2(IMG_H);
    localparam int NW = $clog2(N);

    hf_state_e state_q, state_d;
    logic [N-1:0]  bin_q, aux_q, border_m;
    logic          fs_q, fs_rise, chg_q, ld_ok;
    logic [XW-1:0] rx;
    logic [YW-1:0] ry;
    logic [NW-1:0] ridx;
    logic          rlast, new_bit, clr_bit, scan_step;

    for (genvar gy = 0; gy < IMG_H; gy++) begin : g_row
        for (genvar gx = 0; gx < IMG_W; gx++) begin : g_col
            assign border_m[gy*IMG_W+gx] = (gx == 0) || (gx == IMG_W-1) ||
                                           (gy == 0) || (gy == IMG_H-1);
        end
    end

    assign fs_rise   = frame_sync && !fs_q;
    assign ld_ok     = ld_en && (state_q == ST_IDLE);
    assign scan_step = (state_q == ST_SCAN) && !fs_rise;

    hf_raster #(.W(IMG_W), .H(IMG_H)) u_raster (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (fs_rise),
        .step (scan_step),
        .x    (rx),
        .y    (ry),
        .idx  (ridx),
        .last (rlast)
    );

    hf_decide #(.W(IMG_W), .H(IMG_H)) u_decide (
        .aux_v  (aux_q),
        .bin_bit(bin_q[ridx]),
        .x      (rx),
        .y      (ry),
        .idx    (ridx),
        .new_bit(new_bit),
        .clr    (clr_bit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fs_rise) state_d = ST_SCAN;
            ST_SCAN: if (fs_rise)     state_d = ST_SCAN;
                     else if (rlast) state_d = ST_WRAP;
            ST_WRAP: state_d = fs_rise ? ST_SCAN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and image stores
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q      <= 1'b0;
            bin_q     <= '0;
            aux_q     <= ~border_m;
            chg_q     <= 1'b0;
            done      <= 1'b0;
            pix_valid <= 1'b0;
            pix_idx   <= '0;
            pix_out   <= 8'd0;
        end else begin
            fs_q      <= frame_sync;
            pix_valid <= 1'b0;
            if (ld_ok) begin
                bin_q[ld_addr] <= |ld_pix;
                aux_q          <= ~border_m;
                done           <= 1'b0;
            end
            if (state_q == ST_WRAP && !chg_q) done <= 1'b1;
            if (fs_rise) begin
                chg_q <= 1'b0;
            end else if (state_q == ST_SCAN) begin
                aux_q[ridx] <= new_bit;
                pix_valid   <= 1'b1;
                pix_idx     <= ridx;
                pix_out     <= new_bit ? 8'd255 : 8'd0;
                if (clr_bit) chg_q <= 1'b1;
            end
        end
    end

    AST_BORDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && border_m[pix_idx] |-> pix_out == 8'd0); // R9

    AST_FG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !border_m[pix_idx] && bin_q[pix_idx] |-> pix_out == 8'd255); // R5

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_idx != '0 |-> $past(pix_valid) && pix_idx == $past(pix_idx) + 1'b1); // R3

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !ld_ok |=> done); // R8

    AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_IDLE |=> $stable(bin_q)); // R11
endmodule

// File: tb/hole_fill_tb.sv
module hole_fill_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int H = 8;
    localparam int N = W * H;
    localparam int NW = $clog2(N);

    logic clk = 0, rst_n = 0, frame_sync = 0, ld_en = 0;
    logic [NW-1:0] ld_addr = '0;
    logic [7:0] ld_pix = '0;
    logic pix_valid, done;
    logic [NW-1:0] pix_idx;
    logic [7:0] pix_out;

    int tests = 0, fails = 0;
    bit img[N];
    bit refv[N];
    logic [7:0] got[N];
    int got_n;
    bit idx_ok;
    logic [31:0] lfsr = 32'hACE1_1234;

    hole_fill #(.IMG_W(W), .IMG_H(H)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ld_en(ld_en),
        .ld_addr(ld_addr), .ld_pix(ld_pix), .pix_valid(pix_valid),
        .pix_idx(pix_idx), .pix_out(pix_out), .done(done));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_image();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            ld_en = 1; ld_addr = NW'(i);
            ld_pix = img[i] ? ((i % 3 == 0) ? 8'h01 : 8'hFF) : 8'h00;
        end
        @(negedge clk);
        ld_en = 0;
    endtask

    task automatic collect();
        int started = 0;
        got_n = 0; idx_ok = 1;
        for (int g = 0; g < 4*N; g++) begin
            @(negedge clk);
            if (pix_valid) begin
                if (int'(pix_idx) != got_n) idx_ok = 0;
                if (got_n < N) got[got_n] = pix_out;
                got_n++;
                started = 1;
            end else if (started != 0) break;
        end
    endtask

    task automatic do_pass();
        @(negedge clk); frame_sync = 1;
        @(negedge clk); frame_sync = 0;
        collect();
    endtask

    // fixed point by whole-frame relaxation
    function automatic void build_ref();
        bit a[N], nx[N];
        bit ch;
        for (int p = 0; p < N; p++)
            a[p] = !((p % W) == 0 || (p % W) == W-1 || (p / W) == 0 || (p / W) == H-1);
        do begin
            ch = 0; nx = a;
            for (int y = 1; y < H-1; y++)
                for (int x = 1; x < W-1; x++) begin
                    int p = y*W + x;
                    if (a[p] && !img[p] && (!a[p-W] || !a[p+W] || !a[p-1] || !a[p+1])) begin
                        nx[p] = 0; ch = 1;
                    end
                end
            a = nx;
        end while (ch);
        refv = a;
    endfunction

    function automatic int stream_mismatch();
        int m = 0;
        for (int p = 0; p < N; p++)
            if (got[p] != (refv[p] ? 8'd255 : 8'd0)) m++;
        return m;
    endfunction

    task automatic run_to_done(output int passes);
        passes = 0;
        while (!done && passes < 80) begin
            do_pass();
            passes++;
        end
    endtask

    function automatic void fill_fg();
        for (int p = 0; p < N; p++) img[p] = 1;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int passes, m, first;
        repeat (3) @(negedge clk);
        check(done == 0 && pix_valid == 0, "R1 reset", int'(done) + 2*int'(pix_valid), 0);
        rst_n = 1;

        // all foreground: converges in one pass
        fill_fg(); load_image(); build_ref();
        check(done == 0, "R2 done cleared by load", int'(done), 0);
        do_pass();
        check(got_n == N && idx_ok, "R3 stream length and order", got_n, N);
        check(stream_mismatch() == 0, "R9 border zero, R6 encoding", stream_mismatch(), 0);
        check(done == 1, "R8 done after quiet pass", int'(done), 1);

        // enclosed diamond hole
        fill_fg();
        img[2*W+3] = 0; img[3*W+2] = 0; img[3*W+3] = 0; img[3*W+4] = 0; img[4*W+3] = 0;
        load_image(); build_ref();
        check(done == 0, "R2 done cleared on reload", int'(done), 0);
        do_pass();
        check(got[3*W+3] == 8'd255 && stream_mismatch() == 0, "R5 hole filled", int'(got[3*W+3]), 255);
        check(done == 1, "R8 diamond converges in one pass", int'(done), 1);

        // rightward channel: in-place, one pass clears it
        fill_fg();
        for (int x = 1; x < 6; x++) img[3*W+x] = 0;
        load_image(); build_ref();
        do_pass();
        check(stream_mismatch() == 0, "R7 rightward run cleared in one pass", stream_mismatch(), 0);
        check(done == 0, "R8 not done after changing pass", int'(done), 0);
        do_pass();
        check(done == 1, "R8 done on second pass", int'(done), 1);

        // upward channel: one pixel per pass
        fill_fg();
        for (int y = 2; y < 7; y++) img[y*W+3] = 0;
        load_image(); build_ref();
        for (int k = 1; k <= 5; k++) begin
            do_pass();
            check(done == 0, "R8 upward channel still changing", int'(done), 0);
            check(got[(7-k)*W+3] == 8'd0 && (k == 5 || got[(6-k)*W+3] == 8'd255),
                  "R5 one pixel per pass", int'(got[(7-k)*W+3]), 0);
        end
        do_pass();
        check(done == 1 && stream_mismatch() == 0, "R8 upward channel converged", int'(done), 1);

        // done persists; loads during a pass are ignored
        @(negedge clk); frame_sync = 1;
        @(negedge clk); frame_sync = 0;
        repeat (10) @(negedge clk);
        ld_en = 1; ld_addr = NW'(3*W+3); ld_pix = 8'h00;
        @(negedge clk); ld_en = 0;
        collect();
        check(done == 1, "R11 mid-pass write did not clear done", int'(done), 1);
        do_pass();
        check(stream_mismatch() == 0 && done == 1, "R11 image unchanged, R8 done stays", stream_mismatch(), 0);

        // restart mid-pass
        fill_fg();
        for (int y = 2; y < 7; y++) img[y*W+3] = 0;
        load_image(); build_ref();
        do_pass();
        @(negedge clk); frame_sync = 1;
        @(negedge clk); frame_sync = 0;
        repeat (14) @(negedge clk);
        frame_sync = 1;
        @(negedge clk); frame_sync = 0;
        collect();
        check(got_n == N && idx_ok, "R10 restart streams from index 0", got_n, N);
        passes = 0;
        run_to_done(passes);
        check(done == 1 && stream_mismatch() == 0, "R10 converges after restart", stream_mismatch(), 0);

        // level held high: single pass only
        @(negedge clk); frame_sync = 1;
        collect();
        m = 0;
        for (int c = 0; c < 2*N; c++) begin
            @(negedge clk);
            if (pix_valid) m++;
        end
        frame_sync = 0;
        check(got_n == N && m == 0, "R4 held strobe gives one pass", m, 0);

        // random sweep
        for (int t = 0; t < 24; t++) begin
            for (int p = 0; p < N; p++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                img[p] = (t % 2 == 0) ? lfsr[3] : (lfsr[3] | lfsr[7]);
            end
            load_image(); build_ref();
            run_to_done(passes);
            first = stream_mismatch();
            check(done == 1 && first == 0 && idx_ok, "R5 random image fixed point", first, 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule